// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block holds the hazard-control logic for a five-stage, in-order integer pipeline whose register file has a single write port. It compares the source register numbers of the instruction in execute with the destination registers of the older instructions in the memory and writeback stages. When a match is found, it steers each ALU operand to the newest copy of the value that is still in flight.

The ALU mux selects are fixed. Code 00 takes the register-file read data. Code 01 takes the result held in the memory stage. Code 10 takes the result held in the writeback stage. Code 11 is never produced.

A loaded value is not ready early enough to be forwarded to the instruction directly behind the load. For that case the block raises a stall that holds fetch and decode in place. In the same cycle it raises a bubble request that turns the execute stage into a no-op.

Some cases need no logic here. A producer three slots ahead writes the register file in the first half of the cycle, and decode reads it in the second half. WAR and WAW ordering cannot go wrong, because operands are read in decode and every writeback is done in order by the last stage. The block therefore covers only the two read-after-write cases.

Top module: `fwd_interlock`

## Requirements
- R1: Each operand select (`fwd_a_sel` for execute source 1, `fwd_b_sel` for execute source 2) is 2'b00 for register file, 2'b01 for memory-stage result, 2'b10 for writeback-stage result, and never 2'b11. The two operands are decided independently.
- R2: A source that equals the memory-stage destination gives 2'b01, provided that stage is valid and writes.
- R3: A source that equals a valid, writing writeback-stage destination, with no qualifying memory-stage match, gives 2'b10.
- R4: When both the memory and writeback stages qualify for the same source, the memory stage (the younger result) wins and the select is 2'b01.
- R5: Register 0 is never a dependence. A source of 0 always gives 2'b00, and a load with destination 0 never stalls.
- R6: A producer whose valid bit or write-enable is low is ignored, both for forwarding and for load-use detection.
- R7: A valid, writing load in execute whose nonzero destination equals either decode source raises `stall` and `bubble` in that same cycle.
- R8: A stall lasts exactly one cycle. In the cycle after a stall, `stall` is low whatever the inputs.
- R9: A non-load instruction in execute never causes a stall, even when its destination matches a decode source.
- R10: Reset clears the one-cycle stall history, so a load-use hazard seen right after reset stalls. `bubble` is always equal to `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs1 | input | RW | Decode-stage source 1 |
| id_rs2 | input | RW | Decode-stage source 2 |
| ex_rs1 | input | RW | Execute-stage source 1 |
| ex_rs2 | input | RW | Execute-stage source 2 |
| ex_rd | input | RW | Execute-stage destination |
| ex_wen | input | 1 | Execute-stage write enable |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_valid | input | 1 | Execute-stage slot holds a real instruction |
| mem_rd | input | RW | Memory-stage destination |
| mem_wen | input | 1 | Memory-stage write enable |
| mem_valid | input | 1 | Memory-stage valid |
| wb_rd | input | RW | Writeback-stage destination |
| wb_wen | input | 1 | Writeback-stage write enable |
| wb_valid | input | 1 | Writeback-stage valid |
| fwd_a_sel | output | 2 | ALU operand A source select |
| fwd_b_sel | output | 2 | ALU operand B source select |
| stall | output | 1 | Hold fetch and decode |
| bubble | output | 1 | Turn execute into a no-op |

## Verification
The hardest situation to create is a load-use hazard that is still visible in the cycle right after the stall, because a well-behaved pipeline has already replaced the load with a bubble by then. The stimulus table therefore holds a load-use pattern for two consecutive rows, which shows that the second cycle does not stall. A directed sequence then pulses reset while the hazard is held, which shows that the stall history is cleared. Rows in which the memory and writeback stages carry the same destination, but with one of them disqualified, separate the priority rule from the qualification rule.

// File: rtl/fwd_interlock.sv
module fwd_interlock #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic [RW-1:0] ex_rs1,
  input  logic [RW-1:0] ex_rs2,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic          ex_valid,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_valid,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_wen,
  input  logic          wb_valid,
  output logic [1:0]    fwd_a_sel,
  output logic [1:0]    fwd_b_sel,
  output logic          stall,
  output logic          bubble
);
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b01;
  localparam logic [1:0] SEL_WB  = 2'b10;

  logic mem_live, wb_live, ld_live, ld_hit, stall_q;

  assign mem_live = mem_valid && mem_wen && (mem_rd != '0);
  assign wb_live  = wb_valid  && wb_wen  && (wb_rd  != '0);

  assign fwd_a_sel = (ex_rs1 == '0)                    ? SEL_RF  :
                     (mem_live && (mem_rd == ex_rs1))  ? SEL_MEM :
                     (wb_live  && (wb_rd  == ex_rs1))  ? SEL_WB  : SEL_RF;

  assign fwd_b_sel = (ex_rs2 == '0)                    ? SEL_RF  :
                     (mem_live && (mem_rd == ex_rs2))  ? SEL_MEM :
                     (wb_live  && (wb_rd  == ex_rs2))  ? SEL_WB  : SEL_RF;

  assign ld_live = ex_valid && ex_wen && ex_load && (ex_rd != '0);
  assign ld_hit  = ld_live && ((ex_rd == id_rs1) || (ex_rd == id_rs2));
  assign stall   = ld_hit && !stall_q;
  assign bubble  = stall;

  always_ff @(posedge clk) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= stall;
  end

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_sel != 2'b11) && (fwd_b_sel != 2'b11)); // R1
  AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == '0) |-> (fwd_a_sel == SEL_RF)); // R5
  AST_DEAD_PRODUCERS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_valid && !wb_valid) |-> (fwd_a_sel == SEL_RF && fwd_b_sel == SEL_RF)); // R6
  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_load && ex_valid && ex_wen)); // R7
  AST_NONLOAD_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_load |-> !stall); // R9
  AST_ONE_CYCLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R8
endmodule

// File: tb/fwd_interlock_tb_top.sv
module fwd_interlock_tb_top;
  localparam int RW = 5;
  localparam int NV = 15;

  typedef struct packed {
    logic [4:0] i1, i2, e1, e2, erd;
    logic       ew, el, ev;
    logic [4:0] mrd;
    logic       mw, mv;
    logic [4:0] wrd;
    logic       ww, wv;
    logic [1:0] xa, xb;
    logic       xs;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{5'd1,5'd2, 5'd3,5'd4, 5'd5, 1'b1,1'b0,1'b1, 5'd6,1'b1,1'b1, 5'd7,1'b1,1'b1, 2'b00,2'b00,1'b0}, // R1
    '{5'd1,5'd2, 5'd6,5'd4, 5'd5, 1'b1,1'b0,1'b1, 5'd6,1'b1,1'b1, 5'd7,1'b1,1'b1, 2'b01,2'b00,1'b0}, // R2
    '{5'd1,5'd2, 5'd3,5'd7, 5'd5, 1'b1,1'b0,1'b1, 5'd6,1'b1,1'b1, 5'd7,1'b1,1'b1, 2'b00,2'b10,1'b0}, // R3
    '{5'd1,5'd2, 5'd8,5'd8, 5'd5, 1'b1,1'b0,1'b1, 5'd8,1'b1,1'b1, 5'd8,1'b1,1'b1, 2'b01,2'b01,1'b0}, // R4
    '{5'd1,5'd2, 5'd0,5'd0, 5'd5, 1'b1,1'b0,1'b1, 5'd0,1'b1,1'b1, 5'd0,1'b1,1'b1, 2'b00,2'b00,1'b0}, // R5
    '{5'd1,5'd2, 5'd9,5'd4, 5'd5, 1'b1,1'b0,1'b1, 5'd9,1'b0,1'b1, 5'd9,1'b1,1'b1, 2'b10,2'b00,1'b0}, // R6
    '{5'd1,5'd2, 5'd9,5'd10,5'd5, 1'b1,1'b0,1'b1, 5'd9,1'b1,1'b0, 5'd10,1'b1,1'b0,2'b00,2'b00,1'b0}, // R6
    '{5'd1,5'd2, 5'd3,5'd4, 5'd1, 1'b1,1'b0,1'b1, 5'd6,1'b1,1'b1, 5'd7,1'b1,1'b1, 2'b00,2'b00,1'b0}, // R9
    '{5'd1,5'd2, 5'd3,5'd4, 5'd2, 1'b1,1'b1,1'b1, 5'd6,1'b1,1'b1, 5'd7,1'b1,1'b1, 2'b00,2'b00,1'b1}, // R7
    '{5'd1,5'd2, 5'd3,5'd4, 5'd2, 1'b1,1'b1,1'b1, 5'd6,1'b1,1'b1, 5'd7,1'b1,1'b1, 2'b00,2'b00,1'b0}, // R8
    '{5'd1,5'd2, 5'd3,5'd4, 5'd1, 1'b1,1'b1,1'b1, 5'd6,1'b1,1'b1, 5'd7,1'b1,1'b1, 2'b00,2'b00,1'b1}, // R7
    '{5'd1,5'd2, 5'd3,5'd4, 5'd5, 1'b1,1'b0,1'b1, 5'd6,1'b1,1'b1, 5'd7,1'b1,1'b1, 2'b00,2'b00,1'b0}, // R1
    '{5'd0,5'd2, 5'd3,5'd4, 5'd0, 1'b1,1'b1,1'b1, 5'd6,1'b1,1'b1, 5'd7,1'b1,1'b1, 2'b00,2'b00,1'b0}, // R5
    '{5'd1,5'd2, 5'd3,5'd4, 5'd1, 1'b1,1'b1,1'b0, 5'd6,1'b1,1'b1, 5'd7,1'b1,1'b1, 2'b00,2'b00,1'b0}, // R6
    '{5'd1,5'd2, 5'd3,5'd4, 5'd1, 1'b0,1'b1,1'b1, 5'd6,1'b1,1'b1, 5'd7,1'b1,1'b1, 2'b00,2'b00,1'b0}  // R6
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
  logic [RW-1:0] mem_rd = '0, wb_rd = '0;
  logic ex_wen = 0, ex_load = 0, ex_valid = 0, mem_wen = 0, mem_valid = 0, wb_wen = 0, wb_valid = 0;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic stall, bubble;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fwd_interlock #(.RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen),
    .ex_load(ex_load), .ex_valid(ex_valid), .mem_rd(mem_rd), .mem_wen(mem_wen),
    .mem_valid(mem_valid), .wb_rd(wb_rd), .wb_wen(wb_wen), .wb_valid(wb_valid),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .stall(stall), .bubble(bubble));

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    id_rs1 = v.i1; id_rs2 = v.i2; ex_rs1 = v.e1; ex_rs2 = v.e2; ex_rd = v.erd;
    ex_wen = v.ew; ex_load = v.el; ex_valid = v.ev;
    mem_rd = v.mrd; mem_wen = v.mw; mem_valid = v.mv;
    wb_rd = v.wrd; wb_wen = v.ww; wb_valid = v.wv;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    apply(VEC[0]);
    #5;
    chk("R10 reset sel a", fwd_a_sel, 0);
    chk("R10 reset sel b", fwd_b_sel, 0);
    chk("R10 reset stall", stall, 0);
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      apply(VEC[k]);
      #5;
      chk($sformatf("R1-table row %0d sel a", k), fwd_a_sel, VEC[k].xa);
      chk($sformatf("R1-table row %0d sel b", k), fwd_b_sel, VEC[k].xb);
      chk($sformatf("R7-table row %0d stall", k), stall, VEC[k].xs);
      chk($sformatf("R10 row %0d bubble", k), bubble, VEC[k].xs);
    end
    // R10: stall, reset across an edge, the same hazard stalls again
    @(negedge clk);
    apply(VEC[11]);
    @(negedge clk);
    apply(VEC[8]);
    #5;
    chk("R7 directed stall", stall, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R10 stall after reset", stall, 1);
    chk("R10 bubble after reset", bubble, 1);
    @(negedge clk);
    #5;
    chk("R8 held hazard second cycle", stall, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule